// File: doc/BRIEF.md
# Flag-Setting Data-Processing ALU

A purely combinational 32-bit ALU that executes one data-processing operation per request. It takes a first operand, a second operand that an external shifter has already prepared, the shifter's carry-out, the current NZCV flags, a 4-bit operation code and a set-flags request. It returns the result, a destination write-enable and the next NZCV flag value.

All eight additive operations share one adder. The operands are swapped or inverted and the carry-in is selected to give normal subtraction, reverse subtraction and the carry-chained forms. Logical and move operations go through a separate bitwise unit. A flag unit then merges the new flags with the old ones. The register file, condition evaluation, the shifter and multiplication all sit outside this block.

Top module: `dp_alu`

## Requirements
- R1: Codes (op_i) are 0 AND, 1 XOR, 12 OR, 14 bit-clear (a & ~b), 13 move (b), 15 move-not (~b). Each of these returns that bitwise result.
- R2: Code 4 returns a + b. Code 5 returns a + b + C, where C is nzcv_i[1].
- R3: Code 2 returns a - b. Code 6 returns a - b - (1 - C).
- R4: Code 7 returns b - a. Code 3 returns b - a - (1 - C).
- R5: Codes 8 to 11 (test, test-equivalence, compare, compare-negated) drive we_o low. Every other code drives we_o high.
- R6: For codes outside 8 to 11 with set_flags_i low, nzcv_o equals nzcv_i.
- R7: Codes 8 to 11 update the flags regardless of set_flags_i. Test uses a & b, test-equivalence uses a ^ b, compare uses a - b and compare-negated uses a + b.
- R8: On additive operations that update the flags, nzcv_o[1] is the unsigned carry-out. For subtraction this means no borrow. nzcv_o[0] is signed overflow.
- R9: On logical and move operations that update the flags, nzcv_o[1] equals shift_c_i and nzcv_o[0] equals nzcv_i[0].
- R10: Whenever the flags update, nzcv_o[3] is result bit 31 and nzcv_o[2] is set exactly when the result is zero. The flag packing is N at bit 3, Z at bit 2, C at bit 1 and V at bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | 32 | First operand |
| b_i | input | 32 | Pre-shifted second operand |
| shift_c_i | input | 1 | Shifter carry-out |
| nzcv_i | input | 4 | Current flags {N,Z,C,V} |
| op_i | input | 4 | Operation code |
| set_flags_i | input | 1 | Request flag update |
| result_o | output | 32 | Operation result |
| we_o | output | 1 | Destination write-enable |
| nzcv_o | output | 4 | Next flags {N,Z,C,V} |

## Verification
The bench builds the block at its default width of 32 bits. At that width the bit-31 sign boundary and the 0xFFFFFFFF wrap can be reached directly, so carry, borrow and overflow are checked exactly at their edges. Fixed vectors cover every code with and without a flag request. A shift-register-driven sweep then runs all sixteen codes against a wide-integer model.

// File: rtl/dp_alu_pkg.sv
package dp_alu_pkg;
  localparam int unsigned DATA_W = 32;

  typedef enum logic [3:0] {
    OP_AND  = 4'd0,
    OP_XOR  = 4'd1,
    OP_SUB  = 4'd2,
    OP_RSBC = 4'd3,
    OP_ADD  = 4'd4,
    OP_ADC  = 4'd5,
    OP_SBC  = 4'd6,
    OP_RSUB = 4'd7,
    OP_TEST = 4'd8,
    OP_TEQV = 4'd9,
    OP_CMP  = 4'd10,
    OP_CMPN = 4'd11,
    OP_OR   = 4'd12,
    OP_MOVE = 4'd13,
    OP_BCLR = 4'd14,
    OP_MOVN = 4'd15
  } alu_op_e;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } nzcv_t;
endpackage

// File: rtl/dp_alu_adder.sv
module dp_alu_adder #(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] x_i,
  input  logic [W-1:0] y_i,
  input  logic         cin_i,
  output logic [W-1:0] sum_o,
  output logic         cout_o,
  output logic         ovf_o
);
  localparam int unsigned MSB = W - 1;

  logic [W:0] wide;

  assign wide   = {1'b0, x_i} + {1'b0, y_i} + {{W{1'b0}}, cin_i};
  assign sum_o  = wide[W-1:0];
  assign cout_o = wide[W];
  // like-signed inputs producing opposite-signed sum
  assign ovf_o  = (x_i[MSB] == y_i[MSB]) && (sum_o[MSB] != x_i[MSB]);
endmodule

// File: rtl/dp_alu_logic.sv
module dp_alu_logic
  import dp_alu_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  alu_op_e      op_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] res_o
);
  always_comb begin
    unique case (op_i)
      OP_AND, OP_TEST: res_o = a_i & b_i;
      OP_XOR, OP_TEQV: res_o = a_i ^ b_i;
      OP_OR:           res_o = a_i | b_i;
      OP_BCLR:         res_o = a_i & ~b_i;
      OP_MOVE:         res_o = b_i;
      OP_MOVN:         res_o = ~b_i;
      default:         res_o = '0;
    endcase
  end

  always_comb begin
    if (op_i == OP_BCLR)
      assert_bclr_clears_R1: assert ((res_o & b_i) == '0)
        else $error("bit-clear left a masked bit set");
  end
endmodule

// File: rtl/dp_alu_flags.sv
module dp_alu_flags
  import dp_alu_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] res_i,
  input  logic         arith_i,
  input  logic         update_i,
  input  logic         add_c_i,
  input  logic         add_v_i,
  input  logic         shift_c_i,
  input  nzcv_t        flags_i,
  output nzcv_t        flags_o
);
  nzcv_t fresh;

  always_comb begin
    fresh.n = res_i[W-1];
    fresh.z = (res_i == '0);
    fresh.c = arith_i ? add_c_i : shift_c_i;
    fresh.v = arith_i ? add_v_i : flags_i.v;
    flags_o = update_i ? fresh : flags_i;
  end

  always_comb begin
    if (!update_i)
      assert_flags_hold_R6: assert (flags_o == flags_i)
        else $error("flags moved without update");
    if (update_i && !arith_i)
      assert_logic_cv_R9: assert (flags_o.c == shift_c_i && flags_o.v == flags_i.v)
        else $error("logical op disturbed C/V");
  end
endmodule

// File: rtl/dp_alu.sv
module dp_alu
  import dp_alu_pkg::*;
#(
  parameter int unsigned W = DATA_W
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         shift_c_i,
  input  logic [3:0]   nzcv_i,
  input  logic [3:0]   op_i,
  input  logic         set_flags_i,
  output logic [W-1:0] result_o,
  output logic         we_o,
  output logic [3:0]   nzcv_o
);
  alu_op_e      op;
  nzcv_t        flags_in, flags_out;
  logic [W-1:0] add_x, add_y, add_sum, logic_res;
  logic         add_cin, add_c, add_v;
  logic         is_arith, is_test;

  assign op       = alu_op_e'(op_i);
  assign flags_in = nzcv_t'(nzcv_i);

  // operand steering onto the single shared adder
  always_comb begin
    add_x    = a_i;
    add_y    = b_i;
    add_cin  = 1'b0;
    is_arith = 1'b1;
    is_test  = 1'b0;
    unique case (op)
      OP_ADD:  ;
      OP_ADC:  add_cin = flags_in.c;
      OP_SUB:  begin add_y = ~b_i; add_cin = 1'b1; end
      OP_SBC:  begin add_y = ~b_i; add_cin = flags_in.c; end
      OP_RSUB: begin add_x = b_i; add_y = ~a_i; add_cin = 1'b1; end
      OP_RSBC: begin add_x = b_i; add_y = ~a_i; add_cin = flags_in.c; end
      OP_CMP:  begin add_y = ~b_i; add_cin = 1'b1; is_test = 1'b1; end
      OP_CMPN: is_test = 1'b1;
      OP_TEST, OP_TEQV: begin is_arith = 1'b0; is_test = 1'b1; end
      default: is_arith = 1'b0;
    endcase
  end

  dp_alu_adder #(.W(W)) u_adder (
    .x_i   (add_x),
    .y_i   (add_y),
    .cin_i (add_cin),
    .sum_o (add_sum),
    .cout_o(add_c),
    .ovf_o (add_v)
  );

  dp_alu_logic #(.W(W)) u_logic (
    .op_i (op),
    .a_i  (a_i),
    .b_i  (b_i),
    .res_o(logic_res)
  );

  assign result_o = is_arith ? add_sum : logic_res;
  assign we_o     = ~is_test;

  dp_alu_flags #(.W(W)) u_flags (
    .res_i    (result_o),
    .arith_i  (is_arith),
    .update_i (set_flags_i | is_test),
    .add_c_i  (add_c),
    .add_v_i  (add_v),
    .shift_c_i(shift_c_i),
    .flags_i  (flags_in),
    .flags_o  (flags_out)
  );

  assign nzcv_o = flags_out;

  always_comb begin
    if (op_i[3:2] == 2'b10)
      assert_no_write_R5: assert (!we_o) else $error("compare wrote result");
    if (op == OP_ADD)
      assert_add_sum_R2: assert (result_o == a_i + b_i) else $error("add mismatch");
    if (op == OP_RSUB)
      assert_rsub_diff_R4: assert (result_o == b_i - a_i) else $error("rsub mismatch");
    if (op == OP_MOVE)
      assert_move_pass_R1: assert (result_o == b_i) else $error("move mismatch");
    if (op_i[3:2] == 2'b10 || set_flags_i)
      assert_zero_flag_R10: assert (nzcv_o[2] == (result_o == '0) && nzcv_o[3] == result_o[W-1])
        else $error("N/Z disagree with result");
  end
endmodule

// File: tb/dp_alu_bench.sv
module dp_alu_bench;
  localparam int CLK_PERIOD = 10;
  localparam int W = 32;

  logic         clk = 1'b0;
  logic [W-1:0] a, b, res;
  logic         sc, sf, we;
  logic [3:0]   fin, fout, op;
  int           checks = 0, fails = 0, cycles = 0;
  logic [31:0]  lfsr = 32'hACE1_2468;

  always #(CLK_PERIOD/2) clk = ~clk;

  dp_alu u_dp_alu (
    .a_i(a), .b_i(b), .shift_c_i(sc), .nzcv_i(fin), .op_i(op),
    .set_flags_i(sf), .result_o(res), .we_o(we), .nzcv_o(fout)
  );

  function automatic string tag_of(input logic [3:0] o);
    case (o)
      4'd4, 4'd5: return "R2";
      4'd2, 4'd6: return "R3";
      4'd3, 4'd7: return "R4";
      4'd8, 4'd9, 4'd10, 4'd11: return "R7";
      default: return "R1";
    endcase
  endfunction

  // wide-integer model taken from the requirements
  task automatic model(input logic [3:0] o, input logic [31:0] x, input logic [31:0] y,
                       input logic s_c, input logic [3:0] f, input logic s,
                       output logic [31:0] r, output logic w, output logic [3:0] nf);
    longint ux, uy, sx, sy, ut, st;
    logic c, nc, arith, is_add, upd;
    ux = longint'(x); uy = longint'(y);
    sx = longint'($signed(x)); sy = longint'($signed(y));
    c = f[1]; nc = ~c; arith = 1'b1; is_add = 1'b0;
    ut = 0; st = 0; r = '0;
    case (o)
      4'd4, 4'd11: begin ut = ux + uy; st = sx + sy; is_add = 1'b1; end
      4'd5: begin ut = ux + uy + c; st = sx + sy + c; is_add = 1'b1; end
      4'd2, 4'd10: begin ut = ux - uy; st = sx - sy; end
      4'd6: begin ut = ux - uy - nc; st = sx - sy - nc; end
      4'd7: begin ut = uy - ux; st = sy - sx; end
      4'd3: begin ut = uy - ux - nc; st = sy - sx - nc; end
      default: arith = 1'b0;
    endcase
    case (o)
      4'd0, 4'd8: r = x & y;
      4'd1, 4'd9: r = x ^ y;
      4'd12: r = x | y;
      4'd14: r = x & ~y;
      4'd13: r = y;
      4'd15: r = ~y;
      default: r = ut[31:0];
    endcase
    w   = !(o >= 4'd8 && o <= 4'd11);
    upd = s || !w;
    nf  = f;
    if (upd) begin
      nf[3] = r[31];
      nf[2] = (r == 32'd0);
      if (arith) begin
        nf[1] = is_add ? (ut > 64'sh0FFFF_FFFF) : (ut >= 0);
        nf[0] = (st > 64'sh7FFF_FFFF) || (st < -64'sh8000_0000);
      end else
        nf[1] = s_c;
    end
  endtask

  task automatic run(input string tag, input logic [3:0] o, input logic [31:0] x,
                     input logic [31:0] y, input logic s_c, input logic [3:0] f, input logic s);
    logic [31:0] er; logic ew; logic [3:0] ef;
    @(negedge clk);
    op = o; a = x; b = y; sc = s_c; fin = f; sf = s;
    model(o, x, y, s_c, f, s, er, ew, ef);
    @(posedge clk); #1;
    checks++;
    if (res !== er || we !== ew || fout !== ef) begin
      fails++;
      $display("FAIL %s op=%0d res=%h/%h we=%b/%b nzcv=%b/%b (actual/expected)",
               tag, o, res, er, we, ew, fout, ef);
    end
  endtask

  task automatic t_idle();    // all-zero inputs: AND of zeros, flags held
    run("R1", 4'd0, 0, 0, 0, 4'b0000, 0);
  endtask
  task automatic t_logic();
    run("R1", 4'd12, 32'h0204_0608, 32'h1030_5070, 0, 4'b0000, 0);
    run("R1", 4'd14, 32'hF, 32'h5, 0, 4'b0000, 0);
    run("R1", 4'd15, 32'h0, 32'h0, 0, 4'b0000, 1);
    run("R9", 4'd1, 32'hFFFF_0000, 32'h0000_FFFF, 1, 4'b0001, 1);
    run("R9", 4'd13, 32'h0, 32'h0, 0, 4'b0011, 1);
  endtask
  task automatic t_add();
    run("R2", 4'd5, 32'h1, 32'h1, 0, 4'b0010, 0);
    run("R8", 4'd4, 32'h7FFF_FFFF, 32'h1, 0, 4'b0000, 1);
    run("R10", 4'd4, 32'hFFFF_FFFF, 32'h1, 0, 4'b0000, 1);
  endtask
  task automatic t_sub();
    run("R3", 4'd2, 32'h2, 32'h1, 0, 4'b0000, 1);
    run("R3", 4'd6, 32'h5, 32'h3, 0, 4'b0000, 1);
    run("R8", 4'd2, 32'h8000_0000, 32'h1, 0, 4'b0000, 1);
    run("R8", 4'd2, 32'h0, 32'h1, 0, 4'b0000, 1);
  endtask
  task automatic t_rsub();
    run("R4", 4'd7, 32'h77, 32'h0, 0, 4'b0000, 1);
    run("R4", 4'd3, 32'h3, 32'hA, 0, 4'b0000, 0);
  endtask
  task automatic t_compare();
    run("R5", 4'd10, 32'h4, 32'h4, 0, 4'b0000, 0);
    run("R7", 4'd11, 32'hFFFF_FFFF, 32'h1, 0, 4'b1001, 0);
    run("R7", 4'd8, 32'hF0, 32'h0F, 1, 4'b0000, 0);
    run("R7", 4'd9, 32'h8000_0000, 32'h0, 0, 4'b0011, 1);
  endtask
  task automatic t_hold();
    run("R6", 4'd4, 32'hFFFF_FFFF, 32'h1, 1, 4'b1010, 0);
    run("R6", 4'd15, 32'h0, 32'h0, 0, 4'b0101, 0);
  endtask
  task automatic t_sweep();
    for (int i = 0; i < 400; i++) begin
      logic [31:0] x, y;
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]}; x = lfsr;
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]}; y = lfsr;
      if (i % 7 == 0) y = x;
      run(tag_of(4'(i)), 4'(i), x, y, lfsr[3], lfsr[7:4], lfsr[9]);
    end
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        fails++; checks++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
      end
    end
  end

  initial begin
    a = '0; b = '0; sc = 0; sf = 0; fin = '0; op = '0;
    t_idle();
    t_logic();
    t_add();
    t_sub();
    t_rsub();
    t_compare();
    t_hold();
    t_sweep();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule